// File: doc/BRIEF.md
# Event-Triggered Data Transfer Controller

This block is a single-channel transfer engine that sits between a peripheral's data-ready flag, a simple synchronous memory bus and the CPU's interrupt input. A typical peripheral is a receiver that raises its flag when a byte has arrived. Each time the flag rises while the channel is armed, the engine reads one data unit from a source address and writes it to a destination address. It then steps both addresses according to their modes and decrements a transfer count. After that it pulses a clear back to the peripheral, so the CPU never sees the request.

When a transfer brings the count to zero, the engine does not clear the flag. It disarms itself, and the still-pending request is passed to the CPU as an interrupt so that software can finish the job. While the channel is disarmed, requests bypass the engine and go straight to the interrupt output. An interrupt-select bit lets software ask for every transfer to be handed on to the CPU in this way, not only the last one.

Software sets up and inspects the channel through a small register port. There are four registers: control, source address, destination address and count.

Top module: `evx_xfer_ctrl`

## Requirements
- R1: After reset all four registers read as zero, the bus is idle, no clear pulse is issued, and the interrupt output equals the request input.
- R2: While the enable bit (control bit 0) is 0, the request input drives the interrupt output directly, no bus cycle is issued and the request flag is never cleared.
- R3: One transfer reads the source address and then writes the data read to the destination address. With the size bit (control bit 5) at 0 the transfer is a byte: the upper eight bits of the written data are zero.
- R4: The source step mode (control bits 2:1) behaves as follows after each transfer. 00 and 01 keep the source address fixed, 10 adds the step, and 11 subtracts it. Arithmetic wraps at the address width.
- R5: The destination step mode (control bits 4:3) uses the same encoding as the source mode and is applied to the destination address after each transfer.
- R6: With the size bit at 1 the step is 2 instead of 1, and all 16 data bits are carried.
- R7: A transfer that leaves the count nonzero decrements the count by one and pulses the clear output once. The interrupt output stays low.
- R8: A transfer that brings the count to zero leaves the flag set, clears the enable bit and raises the interrupt output. A count of 0x0080 yields exactly 128 transfers before the interrupt.
- R9: With the interrupt-select bit (control bit 6) at 1, every transfer leaves the flag set and raises the interrupt, and the enable bit stays set. No further transfer starts until the flag has fallen and risen again.
- R10: A bus cycle holds its request, address and direction until ready is seen. The read completes before the write starts, and a zero-wait transfer takes four cycles from the flag rising to the clear pulse's effect.
- R11: When a register-port write and the transfer bookkeeping update fall in the same cycle, the written register takes the port value. The other registers take their stepped values.
- R12: Every register reads back what was written, through the select codes 0 control, 1 source, 2 destination and 3 count. Unused control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_req_i | input | 1 | Peripheral data-ready flag |
| evt_clr_o | output | 1 | One-cycle pulse clearing the peripheral flag |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select |
| cfg_wdata_i | input | RW | Register write data |
| cfg_rdata_o | output | RW | Register read data for the selected register |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | Bus cycle is a write |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |
| bus_ready_i | input | 1 | Bus cycle completes this cycle |

## Verification
A software write to a channel register and the engine's update of the addresses and count can land on the same clock edge. The bench provokes this on a zero-wait bus by counting edges from the moment it raises the flag. It places a count write exactly on the fourth edge, where the bookkeeping update happens. It then reads back both the count and the destination address. The result is judged correct only when the count holds the written value while the destination address has still advanced by one step.

// File: rtl/evx_pkg.sv
package evx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_UPD  = 2'd3
  } evx_state_e;

  typedef enum logic [1:0] {
    AM_HOLD  = 2'b00,
    AM_HOLD2 = 2'b01,
    AM_UP    = 2'b10,
    AM_DOWN  = 2'b11
  } evx_amode_e;

  localparam int CTRL_W = 7;

  typedef struct packed {
    logic       isel;
    logic       size;
    logic [1:0] dmode;
    logic [1:0] smode;
    logic       en;
  } evx_ctrl_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

endpackage

// File: rtl/evx_addr_step.sv
module evx_addr_step #(
  parameter int AW = 16
) (
  input  logic [1:0]    mode_i,
  input  logic          size_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  import evx_pkg::*;

  logic [AW-1:0] step;

  always_comb begin
    step = size_i ? AW'(2) : AW'(1);
    case (evx_amode_e'(mode_i))
      AM_UP:   addr_o = addr_i + step;
      AM_DOWN: addr_o = addr_i - step;
      default: addr_o = addr_i;
    endcase
  end

endmodule

// File: rtl/evx_regs.sv
module evx_regs #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [1:0]          sel_i,
  input  logic [RW-1:0]       wdata_i,
  output logic [RW-1:0]       rdata_o,
  input  logic                upd_i,
  input  logic                last_i,
  input  logic [AW-1:0]       src_nxt_i,
  input  logic [AW-1:0]       dst_nxt_i,
  output evx_pkg::evx_ctrl_t  ctrl_o,
  output logic [AW-1:0]       src_o,
  output logic [AW-1:0]       dst_o,
  output logic [CW-1:0]       cnt_o
);
  import evx_pkg::*;

  evx_ctrl_t     ctrl_q, ctrl_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ctrl_ce, src_ce, dst_ce, cnt_ce;
  logic          wr_ctrl, wr_src, wr_dst, wr_cnt;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign wr_ctrl = wr_i && (sel_i == SEL_CTRL);
  assign wr_src  = wr_i && (sel_i == SEL_SRC);
  assign wr_dst  = wr_i && (sel_i == SEL_DST);
  assign wr_cnt  = wr_i && (sel_i == SEL_CNT);

  assign ctrl_ce = wr_ctrl || (upd_i && last_i);
  assign src_ce  = wr_src  || upd_i;
  assign dst_ce  = wr_dst  || upd_i;
  assign cnt_ce  = wr_cnt  || upd_i;

  // next-state: port write takes priority over the engine update
  always_comb begin
    ctrl_d = ctrl_q;
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    if (upd_i) begin
      src_d = src_nxt_i;
      dst_d = dst_nxt_i;
      cnt_d = cnt_q - CW'(1);
      if (last_i) ctrl_d.en = 1'b0;
    end
    if (wr_ctrl) ctrl_d = evx_ctrl_t'(wdata_i[CTRL_W-1:0]);
    if (wr_src)  src_d  = wdata_i[AW-1:0];
    if (wr_dst)  dst_d  = wdata_i[AW-1:0];
    if (wr_cnt)  cnt_d  = wdata_i[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (src_ce)  src_q  <= src_d;
      if (dst_ce)  dst_q  <= dst_d;
      if (cnt_ce)  cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    case (sel_i)
      SEL_CTRL: rdata_o = RW'(ctrl_q);
      SEL_SRC:  rdata_o = RW'(src_q);
      SEL_DST:  rdata_o = RW'(dst_q);
      default:  rdata_o = RW'(cnt_q);
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && !wr_cnt |=> cnt_q == $past(cnt_q) - CW'(1)); // R7

  AST_LAST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && last_i && !wr_ctrl |=> !ctrl_q.en); // R8

  AST_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata_i[CW-1:0])); // R11

endmodule

// File: rtl/evx_seq.sv
module evx_seq #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          en_i,
  input  logic          isel_i,
  input  logic          size_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ready_i,
  output logic          upd_o,
  output logic          last_o,
  output logic          clr_o,
  output logic          irq_o
);
  import evx_pkg::*;

  localparam int HI_W = DW - 8;

  evx_state_e    state_q, state_d;
  logic [DW-1:0] data_q, data_d;
  logic          data_ce;
  logic          handed_q, handed_d;
  logic          hand;
  logic [DW-1:0] keep_mask;

  assign keep_mask = {{HI_W{size_i}}, 8'hFF};
  assign data_ce   = (state_q == ST_RD) && bus_ready_i;

  always_comb begin
    state_d     = state_q;
    data_d      = bus_rdata_i & keep_mask;
    handed_d    = handed_q && req_i;
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    upd_o       = 1'b0;
    last_o      = 1'b0;
    clr_o       = 1'b0;
    hand        = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_i && en_i && !handed_q) state_d = ST_RD;
      end
      ST_RD: begin
        bus_req_o  = 1'b1;
        bus_addr_o = src_i;
        if (bus_ready_i) state_d = ST_WR;
      end
      ST_WR: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = dst_i;
        bus_wdata_o = data_q;
        if (bus_ready_i) state_d = ST_UPD;
      end
      default: begin
        upd_o    = 1'b1;
        last_o   = (cnt_i == CW'(1));
        hand     = last_o || isel_i;
        clr_o    = !hand;
        handed_d = hand;
        state_d  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      data_q   <= '0;
      handed_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      handed_q <= handed_d;
      if (data_ce) data_q <= data_d;
    end
  end

  assign irq_o = req_i && (!en_i || handed_q);

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)); // R10

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i && !bus_req_o |=> !bus_req_o); // R2

  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> !irq_o && !bus_req_o); // R7

  AST_LAST_HANDS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o && last_o |=> handed_q); // R8

endmodule

// File: rtl/evx_xfer_ctrl.sv
module evx_xfer_ctrl #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_req_i,
  output logic          evt_clr_o,
  output logic          cpu_irq_o,
  input  logic          cfg_wr_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [RW-1:0] cfg_wdata_i,
  output logic [RW-1:0] cfg_rdata_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ready_i
);
  import evx_pkg::*;

  localparam int NSTEP = 2;

  logic [1:0]    rst_sync_q;
  logic          rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  evx_ctrl_t     ctrl;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic          upd, last;

  logic [AW-1:0] cur_a  [NSTEP];
  logic [AW-1:0] nxt_a  [NSTEP];
  logic [1:0]    mode_a [NSTEP];

  assign cur_a[0]  = src;
  assign cur_a[1]  = dst;
  assign mode_a[0] = ctrl.smode;
  assign mode_a[1] = ctrl.dmode;

  for (genvar k = 0; k < NSTEP; k++) begin : g_step
    evx_addr_step #(.AW(AW)) i_step (
      .mode_i (mode_a[k]),
      .size_i (ctrl.size),
      .addr_i (cur_a[k]),
      .addr_o (nxt_a[k])
    );
  end

  evx_regs #(.AW(AW), .CW(CW), .RW(RW)) i_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .wr_i      (cfg_wr_i),
    .sel_i     (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .upd_i     (upd),
    .last_i    (last),
    .src_nxt_i (nxt_a[0]),
    .dst_nxt_i (nxt_a[1]),
    .ctrl_o    (ctrl),
    .src_o     (src),
    .dst_o     (dst),
    .cnt_o     (cnt)
  );

  evx_seq #(.AW(AW), .CW(CW), .DW(DW)) i_seq (
    .clk         (clk),
    .rst_n       (rst_ns),
    .req_i       (evt_req_i),
    .en_i        (ctrl.en),
    .isel_i      (ctrl.isel),
    .size_i      (ctrl.size),
    .cnt_i       (cnt),
    .src_i       (src),
    .dst_i       (dst),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ready_i (bus_ready_i),
    .upd_o       (upd),
    .last_o      (last),
    .clr_o       (evt_clr_o),
    .irq_o       (cpu_irq_o)
  );

endmodule

// File: tb/test_evx_xfer_ctrl.sv
module test_evx_xfer_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flag = 1'b0;
  logic        evt_clr, cpu_irq;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] cfg_rdata;
  logic        bus_req, bus_we, bus_ready;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  evx_xfer_ctrl i_evx_xfer_ctrl (
    .clk (clk), .rst_n (rst_n),
    .evt_req_i (flag), .evt_clr_o (evt_clr), .cpu_irq_o (cpu_irq),
    .cfg_wr_i (cfg_wr), .cfg_sel_i (cfg_sel), .cfg_wdata_i (cfg_wdata), .cfg_rdata_o (cfg_rdata),
    .bus_req_o (bus_req), .bus_we_o (bus_we), .bus_addr_o (bus_addr),
    .bus_wdata_o (bus_wdata), .bus_rdata_i (bus_rdata), .bus_ready_i (bus_ready)
  );

  // bus memory, peripheral flag and monitors
  logic [15:0] mem [1024];
  int          stall = 0;
  int          wait_cnt = 0;
  int          wr_cnt = 0;
  int          bus_cycles = 0;
  int          hold_err = 0;
  logic        prev_wait = 1'b0;
  logic [15:0] prev_addr = 16'h0;
  logic        prev_we = 1'b0;
  logic        pre_we = 1'b0;
  logic [9:0]  pre_addr = 10'h0;
  logic [15:0] pre_data = 16'h0;
  logic        set_p = 1'b0;
  logic        drop_p = 1'b0;

  assign bus_ready = bus_req && (wait_cnt >= stall);
  assign bus_rdata = mem[bus_addr[9:0]];

  always @(posedge clk) begin
    if (bus_req && !bus_ready) wait_cnt <= wait_cnt + 1;
    else                       wait_cnt <= 0;
    if (bus_req && bus_we && bus_ready) begin
      mem[bus_addr[9:0]] <= bus_wdata;
      wr_cnt <= wr_cnt + 1;
    end else if (pre_we) begin
      mem[pre_addr] <= pre_data;
    end
    if (bus_req) bus_cycles <= bus_cycles + 1;
    if (evt_clr || drop_p) flag <= 1'b0;
    else if (set_p)        flag <= 1'b1;
    if (prev_wait && bus_req && (bus_addr != prev_addr || bus_we != prev_we))
      hold_err <= hold_err + 1;
    prev_wait <= bus_req && !bus_ready;
    prev_addr <= bus_addr;
    prev_we   <= bus_we;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output int d);
    @(negedge clk); cfg_sel = s; #1; d = int'(cfg_rdata);
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); pre_we = 1'b1; pre_addr = a[9:0]; pre_data = d;
    @(negedge clk); pre_we = 1'b0;
  endtask

  task automatic raise();
    @(negedge clk); set_p = 1'b1;
    @(negedge clk); set_p = 1'b0;
  endtask

  task automatic lower();
    @(negedge clk); drop_p = 1'b1;
    @(negedge clk); drop_p = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      n++;
      if (!flag || cpu_irq) break;
    end
  endtask

  typedef struct packed {
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic        sz;
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] data;
    logic [15:0] esrc;
    logic [15:0] edst;
    logic [15:0] ewd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b10, 1'b0, 16'h0100, 16'h0200, 16'hA55A, 16'h0100, 16'h0201, 16'h005A},
    '{2'b01, 2'b10, 1'b0, 16'h0110, 16'h0210, 16'h1234, 16'h0110, 16'h0211, 16'h0034},
    '{2'b10, 2'b00, 1'b0, 16'h0120, 16'h0220, 16'h00FF, 16'h0121, 16'h0220, 16'h00FF},
    '{2'b11, 2'b11, 1'b0, 16'h0130, 16'h0230, 16'hBEEF, 16'h012F, 16'h022F, 16'h00EF},
    '{2'b10, 2'b10, 1'b1, 16'h0140, 16'h0240, 16'hBEEF, 16'h0142, 16'h0242, 16'hBEEF},
    '{2'b11, 2'b10, 1'b1, 16'h0150, 16'h0250, 16'h1357, 16'h014E, 16'h0252, 16'h1357},
    '{2'b00, 2'b11, 1'b1, 16'h0000, 16'h0000, 16'h2468, 16'h0000, 16'hFFFE, 16'h2468},
    '{2'b10, 2'b10, 1'b1, 16'hFFFF, 16'h0300, 16'h7777, 16'h0001, 16'h0302, 16'h7777}
  };

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    int v, n, w0, b0;
    for (int a = 0; a < 1024; a++) mem[a] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd_reg(2'(s), v); chk("R1 register after reset", v, 0);
    end
    chk("R1 bus idle", int'(bus_req), 0);
    chk("R1 no clear", int'(evt_clr), 0);
    chk("R1 irq follows request", int'(cpu_irq), 0);

    // vector table: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      poke(VECS[i].src, VECS[i].data);
      if (VECS[i].dst != VECS[i].src) poke(VECS[i].dst, 16'hDEAD);
      wr_reg(2'd1, VECS[i].src);
      wr_reg(2'd2, VECS[i].dst);
      wr_reg(2'd3, 16'd5);
      wr_reg(2'd0, 16'h0001 | (16'(VECS[i].sm) << 1) | (16'(VECS[i].dm) << 3) | (16'(VECS[i].sz) << 5));
      raise();
      wait_done(n);
      if (i == 0) chk("R10 zero-wait transfer latency", n, 4);
      chk("R7 flag cleared", int'(flag), 0);
      chk("R7 no irq", int'(cpu_irq), 0);
      chk("R3 R6 data written", int'(mem[VECS[i].edst == 16'hFFFE ? 10'h0 : VECS[i].dst[9:0]]), int'(VECS[i].ewd));
      rd_reg(2'd1, v); chk("R4 source step", v, int'(VECS[i].esrc));
      rd_reg(2'd2, v); chk("R5 destination step", v, int'(VECS[i].edst));
      rd_reg(2'd3, v); chk("R7 count decrement", v, 4);
    end

    // R12 readback
    wr_reg(2'd1, 16'hABCD); rd_reg(2'd1, v); chk("R12 source readback", v, 16'hABCD);
    wr_reg(2'd2, 16'h1357); rd_reg(2'd2, v); chk("R12 destination readback", v, 16'h1357);
    wr_reg(2'd3, 16'h0F0F); rd_reg(2'd3, v); chk("R12 count readback", v, 16'h0F0F);
    wr_reg(2'd0, 16'h007E); rd_reg(2'd0, v); chk("R12 control readback", v, 16'h007E);
    wr_reg(2'd0, 16'hFF80); rd_reg(2'd0, v); chk("R12 unused control bits", v, 0);

    // R2 bypass while disarmed
    wr_reg(2'd0, 16'h0010);
    b0 = bus_cycles;
    raise();
    chk("R2 irq bypass", int'(cpu_irq), 1);
    repeat (10) @(negedge clk);
    chk("R2 no bus cycles", bus_cycles - b0, 0);
    chk("R2 flag not cleared", int'(flag), 1);
    lower();
    chk("R2 irq drops with request", int'(cpu_irq), 0);

    // R10 wait states
    stall = 3;
    poke(16'h01A0, 16'h4321);
    wr_reg(2'd1, 16'h01A0); wr_reg(2'd2, 16'h02A0); wr_reg(2'd3, 16'd5);
    wr_reg(2'd0, 16'h0035);
    raise();
    wait_done(n);
    chk("R10 stalled transfer latency", n, 10);
    chk("R10 stalled data", int'(mem[10'h2A0]), 16'h4321);
    stall = 0;

    // R9 interrupt on every transfer
    poke(16'h0020, 16'h0099);
    wr_reg(2'd1, 16'h0020); wr_reg(2'd2, 16'h0060); wr_reg(2'd3, 16'd3);
    wr_reg(2'd0, 16'h0051);
    raise();
    wait_done(n);
    chk("R9 irq raised", int'(cpu_irq), 1);
    chk("R9 flag kept", int'(flag), 1);
    w0 = wr_cnt;
    repeat (8) @(negedge clk);
    chk("R9 no repeat on held flag", wr_cnt - w0, 0);
    rd_reg(2'd0, v); chk("R9 enable kept", v, 16'h0051);
    rd_reg(2'd3, v); chk("R9 count after first", v, 2);
    lower();
    chk("R9 irq drops", int'(cpu_irq), 0);
    raise();
    wait_done(n);
    rd_reg(2'd3, v); chk("R9 second transfer count", v, 1);
    lower();

    // R11 port write collides with bookkeeping update
    wr_reg(2'd1, 16'h0010); wr_reg(2'd2, 16'h0080); wr_reg(2'd3, 16'd5);
    wr_reg(2'd0, 16'h0011);
    raise();
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_wdata = 16'h0050;
    @(negedge clk); cfg_wr = 1'b0;
    rd_reg(2'd3, v); chk("R11 port write wins count", v, 16'h0050);
    rd_reg(2'd2, v); chk("R11 destination still stepped", v, 16'h0081);

    // R8 128 transfers then hand-off
    wr_reg(2'd1, 16'h0010); wr_reg(2'd2, 16'h0040); wr_reg(2'd3, 16'h0080);
    wr_reg(2'd0, 16'h0011);
    w0 = wr_cnt;
    begin
      int bad = 0;
      for (int i = 0; i < 128; i++) begin
        poke(16'h0010, 16'((i + 1) & 8'hFF));
        raise();
        wait_done(n);
        if (i < 127 && (flag || cpu_irq)) bad++;
      end
      chk("R8 intermediate transfers absorbed", bad, 0);
    end
    chk("R8 transfer total", wr_cnt - w0, 128);
    chk("R8 flag held", int'(flag), 1);
    chk("R8 irq raised", int'(cpu_irq), 1);
    rd_reg(2'd0, v); chk("R8 enable cleared", v, 16'h0010);
    rd_reg(2'd3, v); chk("R8 count zero", v, 0);
    rd_reg(2'd2, v); chk("R8 destination end", v, 16'h00C0);
    chk("R8 first data", int'(mem[10'h040]), 16'h0001);
    chk("R8 last data", int'(mem[10'h0BF]), 16'h0080);
    lower();

    chk("R10 bus hold violations", hold_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule